// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block is the synchronous logic core of a processor supervisor. Comparators outside it turn the supply and two auxiliary monitored voltages into digital undervoltage flags. The block combines those flags with an active-low manual-reset input and produces an active-low system reset. Once a reset condition clears, the reset is held for a fixed number of cycles, and that hold also debounces a pushbutton on the manual-reset pin.

The block also runs a watchdog that software keeps alive by toggling the `wdi` input. When the watchdog expires, a latched, active-low alarm is raised on `wdo_n`, which is meant for a non-maskable interrupt line. The alarm also follows any undervoltage flag directly.

A static `variant` input picks one of three behaviours:
- a plain alarm latch;
- an alarm latch that manual reset can also clear;
- no alarm output, where an expired watchdog fires a full reset pulse instead.

Timeout and pulse width are parameters given in clock cycles.

Top module: `wdt_supervisor`

## Requirements
- R1: While `rst_n` is low and right after it rises, `sys_rst_n` is 0 and `wdo_n` is 1. `sys_rst_n` goes to 1 exactly `PULSE_CYC` clock edges after `rst_n` rises, provided no reset condition is present.
- R2: A reset condition is any of `uv_core`, `uv_aux_a` or `uv_aux_b` high, or the synchronized `mr_n` low. A reset condition sampled at a clock edge drives `sys_rst_n` to 0 after that edge. `sys_rst_n` returns to 1 only `PULSE_CYC` edges after the last edge that saw a condition, so a condition that recurs during the pulse restarts it.
- R3: With `variant` not equal to 2, `wdo_n` is 0 in the same cycle that any undervoltage flag is high. It returns to 1 as soon as the flags clear, unless the alarm is latched.
- R4: With `variant` 0 or 1, if no `wdi` edge is seen for `TIMEOUT_CYC` cycles after reset releases, `wdo_n` latches to 0. It stays at 0 until it is cleared.
- R5: The alarm latch is cleared by either a rising or a falling edge of `wdi`. A `wdi` pulse lasting a single clock cycle is detected, and the clearing shows at `wdo_n` within 4 cycles.
- R6: With `variant` 1, `mr_n` low also clears the alarm latch. With `variant` 0, `mr_n` low leaves the alarm latch set.
- R7: The watchdog counter is held at zero while `sys_rst_n` is 0 and starts counting at the edge where the reset releases. A timeout therefore occurs `TIMEOUT_CYC` edges after that release.
- R8: With `variant` 2, `wdo_n` is always 1, and a watchdog timeout drives `sys_rst_n` to 0 for `PULSE_CYC` cycles.
- R9: Each detected `wdi` edge restarts the watchdog count from zero, so toggling `wdi` at intervals shorter than `TIMEOUT_CYC` never raises the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low power-on reset of the logic |
| uv_core | input | 1 | Supply undervoltage flag, active high, synchronous |
| uv_aux_a | input | 1 | First auxiliary undervoltage flag, active high, synchronous |
| uv_aux_b | input | 1 | Second auxiliary undervoltage flag, active high, synchronous |
| mr_n | input | 1 | Manual reset, active low, asynchronous |
| wdi | input | 1 | Watchdog kick input, asynchronous, either edge counts |
| variant | input | 2 | Static behaviour select: 0 plain latch, 1 latch cleared by manual reset, 2 timeout causes reset |
| sys_rst_n | output | 1 | Active-low system reset |
| wdo_n | output | 1 | Active-low watchdog alarm |

## Verification
The two failures of most concern are a counter that keeps running during reset and an alarm latch that drops too early. A counter that is not held during reset moves the timeout earlier than `TIMEOUT_CYC` edges after release. The bench samples `wdo_n` exactly one cycle before and one cycle after the expected edge, so the shift shows up at that point. A latch that clears spontaneously, or on manual reset in the plain variant, shows as `wdo_n` returning to 1 within the tens of cycles the bench holds the alarm. A wrong pulse counter moves the release of `sys_rst_n` off its exact cycle, and the bench catches this both after power-on and after a restarted pulse.

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int unsigned TIMEOUT_CYC = 320_000_000,
  parameter int unsigned PULSE_CYC   = 28_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uv_core,
  input  logic       uv_aux_a,
  input  logic       uv_aux_b,
  input  logic       mr_n,
  input  logic       wdi,
  input  logic [1:0] variant,
  output logic       sys_rst_n,
  output logic       wdo_n
);
  localparam int WW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [WW-1:0] WD_LAST = WW'(TIMEOUT_CYC - 1);
  localparam logic [PW-1:0] PULSE   = PW'(PULSE_CYC);

  logic [1:0]    mr_sync, wdi_sync;
  logic          wdi_prev, wd_lat;
  logic [WW-1:0] wd_cnt;
  logic [PW-1:0] rp_cnt;

  wire uv_any    = uv_core | uv_aux_a | uv_aux_b;
  wire mr_act    = ~mr_sync[1];
  wire wdi_edge  = wdi_sync[1] ^ wdi_prev;
  wire to_reset  = (variant == 2'd2);
  wire rst_hold  = (rp_cnt != '0);
  wire wd_fire   = !rst_hold && !wdi_edge && (wd_cnt == WD_LAST);
  wire rst_cond  = uv_any | mr_act | (to_reset & wd_fire);
  wire lat_clear = to_reset | wdi_edge | ((variant == 2'd1) & mr_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_sync  <= 2'b11;
      wdi_sync <= 2'b00;
      wdi_prev <= 1'b0;
    end else begin
      mr_sync  <= {mr_sync[0], mr_n};
      wdi_sync <= {wdi_sync[0], wdi};
      wdi_prev <= wdi_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rp_cnt <= PULSE;
    else if (rst_cond) rp_cnt <= PULSE;
    else if (rst_hold) rp_cnt <= rp_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             wd_cnt <= '0;
    else if (rst_hold || wdi_edge || wd_fire) wd_cnt <= '0;
    else                                    wd_cnt <= wd_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wd_lat <= 1'b0;
    else if (lat_clear) wd_lat <= 1'b0;
    else if (wd_fire)   wd_lat <= 1'b1;
  end

  assign sys_rst_n = ~rst_hold;
  assign wdo_n     = to_reset ? 1'b1 : ~(wd_lat | uv_any);
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uv_any,
  input logic [1:0] variant,
  input logic       sys_rst_n,
  input logic       wdo_n,
  input logic       mr_s,
  input logic       wdi_edge,
  input logic       wd_cnt_zero,
  input logic       wd_lat
);
  p_uv_alarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_any && variant != 2'd2) |-> !wdo_n);

  p_uv_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uv_any |=> !sys_rst_n);

  p_release_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(!uv_any && mr_s));

  p_cnt_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |=> wd_cnt_zero);

  p_latch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_lat && !wdi_edge && variant != 2'd2 && !(variant == 2'd1 && !mr_s)) |=> wd_lat);

  p_no_alarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (variant == 2'd2) |-> wdo_n);
endmodule

bind wdt_supervisor wdt_supervisor_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .uv_any      (uv_any),
  .variant     (variant),
  .sys_rst_n   (sys_rst_n),
  .wdo_n       (wdo_n),
  .mr_s        (mr_sync[1]),
  .wdi_edge    (wdi_edge),
  .wd_cnt_zero (wd_cnt == '0),
  .wd_lat      (wd_lat)
);

// File: tb/tb_wdt_supervisor.sv
`timescale 1ns/1ps
module tb_wdt_supervisor;
  localparam int T = 40;
  localparam int P = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv_core = 1'b0, uv_aux_a = 1'b0, uv_aux_b = 1'b0;
  logic mr_n = 1'b1, wdi = 1'b0;
  logic [1:0] variant = 2'd0;
  logic sys_rst_n, wdo_n;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_supervisor #(.TIMEOUT_CYC(T), .PULSE_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .uv_core(uv_core), .uv_aux_a(uv_aux_a),
    .uv_aux_b(uv_aux_b), .mr_n(mr_n), .wdi(wdi), .variant(variant),
    .sys_rst_n(sys_rst_n), .wdo_n(wdo_n));

  // entry: {uv_b,uv_a,uv_core, mr_n, cycles[7:0], exp sys_rst_n, exp wdo_n}
  localparam int NV = 11;
  localparam logic [13:0] VEC [NV] = '{
    {3'b001, 1'b1, 8'd3,  1'b0, 1'b0},
    {3'b000, 1'b1, 8'd1,  1'b0, 1'b1},
    {3'b000, 1'b1, 8'd18, 1'b1, 1'b1},
    {3'b010, 1'b1, 8'd1,  1'b0, 1'b0},
    {3'b000, 1'b1, 8'd20, 1'b1, 1'b1},
    {3'b100, 1'b1, 8'd2,  1'b0, 1'b0},
    {3'b000, 1'b1, 8'd20, 1'b1, 1'b1},
    {3'b000, 1'b0, 8'd4,  1'b0, 1'b1},
    {3'b000, 1'b1, 8'd24, 1'b1, 1'b1},
    {3'b101, 1'b0, 8'd2,  1'b0, 1'b0},
    {3'b000, 1'b1, 8'd24, 1'b1, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic restart(input logic [1:0] v);
    @(negedge clk);
    rst_n = 1'b0; uv_core = 0; uv_aux_a = 0; uv_aux_b = 0; mr_n = 1; wdi = 0; variant = v;
    tick(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, got running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 power-on state and pulse length
    restart(2'd0);
    chk("R1", "sys_rst_n at release", sys_rst_n, 1'b0);
    chk("R1", "wdo_n at release", wdo_n, 1'b1);
    tick(P - 1);
    chk("R1", "sys_rst_n before pulse end", sys_rst_n, 1'b0);
    tick(1);
    chk("R1", "sys_rst_n after pulse", sys_rst_n, 1'b1);

    // R4/R7 timeout measured from release
    tick(T - 1);
    chk("R7", "wdo_n one cycle before timeout", wdo_n, 1'b1);
    tick(1);
    chk("R4", "wdo_n at timeout", wdo_n, 1'b0);
    chk("R4", "sys_rst_n untouched by alarm", sys_rst_n, 1'b1);
    tick(30);
    chk("R4", "wdo_n stays latched", wdo_n, 1'b0);

    // R6 variant 0: manual reset leaves alarm set
    mr_n = 1'b0; tick(4);
    chk("R2", "sys_rst_n on manual reset", sys_rst_n, 1'b0);
    chk("R6", "wdo_n kept by mr in variant 0", wdo_n, 1'b0);
    mr_n = 1'b1; tick(P + 6);
    chk("R6", "wdo_n still latched after mr", wdo_n, 1'b0);

    // R5 single-cycle wdi pulse clears latch
    wdi = 1'b1; tick(1); wdi = 1'b0; tick(4);
    chk("R5", "wdo_n cleared by one-cycle pulse", wdo_n, 1'b1);

    // R9 periodic kicks keep alarm off
    for (int i = 0; i < 8; i++) begin
      wdi = ~wdi; tick(T / 2);
    end
    chk("R9", "wdo_n with regular kicks", wdo_n, 1'b1);
    tick(T + 5);
    chk("R9", "wdo_n after kicks stop", wdo_n, 1'b0);
    wdi = ~wdi; tick(4);
    chk("R5", "wdo_n cleared by falling or rising edge", wdo_n, 1'b1);

    // R2/R3 vector table in variant 0
    restart(2'd0); tick(P);
    for (int k = 0; k < NV; k++) begin
      {uv_aux_b, uv_aux_a, uv_core} = VEC[k][13:11];
      mr_n = VEC[k][10];
      tick(int'(VEC[k][9:2]));
      chk("R2", $sformatf("vector %0d sys_rst_n", k), sys_rst_n, VEC[k][1]);
      chk("R3", $sformatf("vector %0d wdo_n", k), wdo_n, VEC[k][0]);
    end

    // R2 pulse restart
    restart(2'd0); tick(P);
    uv_core = 1'b1; tick(1); uv_core = 1'b0;
    tick(P / 2);
    chk("R2", "low mid pulse", sys_rst_n, 1'b0);
    uv_aux_b = 1'b1; tick(1); uv_aux_b = 1'b0;
    tick(P - 1);
    chk("R2", "restarted pulse still low", sys_rst_n, 1'b0);
    tick(1);
    chk("R2", "restarted pulse ends", sys_rst_n, 1'b1);

    // R7 counter held during long manual reset
    restart(2'd0); tick(P);
    mr_n = 1'b0; tick(3 * T);
    chk("R7", "wdo_n during long reset", wdo_n, 1'b1);
    mr_n = 1'b1;
    tick(P + 1);
    chk("R7", "sys_rst_n before release", sys_rst_n, 1'b0);
    tick(1);
    chk("R7", "sys_rst_n released", sys_rst_n, 1'b1);
    tick(T - 1);
    chk("R7", "wdo_n one cycle before timeout", wdo_n, 1'b1);
    tick(1);
    chk("R7", "wdo_n at timeout", wdo_n, 1'b0);

    // R6 variant 1: manual reset clears alarm
    restart(2'd1); tick(P); tick(T);
    chk("R4", "variant 1 timeout", wdo_n, 1'b0);
    mr_n = 1'b0; tick(4);
    chk("R6", "wdo_n cleared by mr in variant 1", wdo_n, 1'b1);
    mr_n = 1'b1; tick(P + 4);

    // R8 variant 2: timeout fires reset pulse
    restart(2'd2); tick(P);
    tick(T - 1);
    chk("R8", "sys_rst_n before timeout", sys_rst_n, 1'b1);
    tick(1);
    chk("R8", "sys_rst_n at timeout", sys_rst_n, 1'b0);
    chk("R8", "wdo_n held high", wdo_n, 1'b1);
    tick(P - 1);
    chk("R8", "reset pulse still low", sys_rst_n, 1'b0);
    tick(1);
    chk("R8", "reset pulse ends", sys_rst_n, 1'b1);
    uv_aux_a = 1'b1; tick(1);
    chk("R8", "wdo_n high under undervoltage", wdo_n, 1'b1);
    uv_aux_a = 1'b0; tick(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule